// File: doc/BRIEF.md
# SMBus Clock-Configuration Register Slave

This block is the serial control port of a clock generator. A host on a two-wire SMBus reads and writes a small bank of byte-wide control registers that steer the clock-stop and watchdog logic. The slave watches the bus lines through a synchronizer clocked by the chip clock and pulls the data line low through an open-drain enable. It never drives the line high.

The command byte after the address selects the transfer. With its top bit set, the next byte is a single register access at the offset given by the low seven bits. With its top bit clear, the transfer is a counted block that always begins at the first implemented register and moves upward. Implemented registers start at index 4, because the low indices on the shared address belong to other devices. Index 4 holds a mode bit that decides whether the frequency-select bits come from software or from the latched hardware straps. Index 5 is a read-only copy of those straps.

The register contents leave the block as one flat vector for the neighbouring clock logic. Byte k of that vector holds index 4+k.

Top module: `smbus_clkcfg_slave`

## Requirements
- R1: The slave acknowledges only the 7-bit address 0x69 (0xD2 write, 0xD3 read). After any other address it sends no acknowledge and ignores the bus until the next start condition, and it never drives SDA while idle.
- R2: Byte write: address+W, a command with bit 7 = 1 and the offset in bits 6:0, then one data byte, all acknowledged. The data lands in the register at that offset, and the register bank changes only on an SCL falling edge.
- R3: Byte read: address+W, command (bit 7 = 1, offset in bits 6:0), repeated start, address+R. The slave then returns the register at that offset, MSB first, and releases the bus after the master's NACK.
- R4: Block write: address+W, command 0x00, a count byte, then data bytes written to indices 4, 5, 6 and upward. Every byte is acknowledged. Data bytes beyond the count are discarded, and a stop after any complete byte keeps the bytes already written.
- R5: Block read: address+W, command 0x00, repeated start, address+R. The slave sends a count equal to the number of implemented registers (11), then the registers from index 4 upward until the master NACKs.
- R6: Register 4 bit 3 selects software mode. The stored value of bit 3 before a write decides whether that write may change bits 7:4 and 2. In hardware mode those bits read as the straps: bits 7:4 = FS3, FS2, FS1, FS0 and bit 2 = FS4. Bits 3, 1 and 0 are always writable.
- R7: Register 5 reads {2'b00, MULT0 strap, FS4..FS0 straps} with FS0 in bit 0, and writes to it have no effect.
- R8: Indices below 4 or at 4+11 and above read as 0x00, and writes to them are discarded while still acknowledged.
- R9: SDA is pulled low only for an acknowledge or a 0 data bit during a read, and the drive enable changes only while SCL is low.
- R10: After reset the drive enable is off, registers 4 and 6 to 14 hold 0x00, and the outputs show the straps where R6 and R7 place them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SMBus clock line as seen at the pad |
| sda_i | input | 1 | SMBus data line as seen at the pad |
| sda_oe | output | 1 | Open-drain enable: 1 pulls SDA low |
| strap_fs | input | 5 | Latched frequency-select straps FS4..FS0 |
| strap_mult | input | 1 | Latched current-multiplier strap |
| cfg_out | output | 88 | Effective register bank, byte k = index 4+k |

## Verification
The hardest cases to reach are inside a single transaction: a block write whose master keeps sending after the count runs out, and a block read that runs one byte past the last implemented register before the NACK. The bench reaches both with its own bit-level master tasks. It sends a count smaller than the bytes that follow, and it acknowledges through the whole bank before it NACKs the next byte. The mode-gated frequency bits are tested by a sequence of byte writes that switch the mode bit on and off, so that the pre-write mode decides each outcome.

// File: rtl/smbus_clkcfg_slave.sv
module smbus_clkcfg_slave #(
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         NUM_REGS    = 11,
  parameter int         BASE_IDX    = 4,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    scl_i,
  input  logic                    sda_i,
  output logic                    sda_oe,
  input  logic [4:0]              strap_fs,
  input  logic                    strap_mult,
  output logic [NUM_REGS*8-1:0]   cfg_out
);

  localparam logic [7:0] BLK_COUNT = 8'(NUM_REGS);
  localparam logic [6:0] IDX_FIRST = 7'(BASE_IDX);

  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_RXACK, ST_TX, ST_TXACK} st_t;
  typedef enum logic [1:0] {PH_ADDR, PH_CMD, PH_CNT, PH_DATA} ph_t;

  logic [SYNC_STAGES:0] scl_p, sda_p;
  logic scl_now, scl_old, sda_now, sda_old;
  logic scl_rise, scl_fall, start_det, stop_det;

  st_t        st;
  ph_t        ph, ph_next;
  logic [3:0] bitcnt;
  logic [7:0] shreg, wr_left, rd_val, tx_byte;
  logic [6:0] idx;
  logic       rw, blk, cnt_pend, mst_ack;
  logic       wr_fire, idle_w;
  logic [7:0] ctl0_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[SYNC_STAGES-1:0], scl_i};
      sda_p <= {sda_p[SYNC_STAGES-1:0], sda_i};
    end

  assign scl_now   = scl_p[SYNC_STAGES-1];
  assign scl_old   = scl_p[SYNC_STAGES];
  assign sda_now   = sda_p[SYNC_STAGES-1];
  assign sda_old   = sda_p[SYNC_STAGES];
  assign scl_rise  = scl_now & ~scl_old;
  assign scl_fall  = ~scl_now & scl_old;
  assign start_det = scl_now & scl_old & sda_old & ~sda_now;
  assign stop_det  = scl_now & scl_old & ~sda_old & sda_now;
  assign idle_w    = (st == ST_IDLE);

  always_comb
    case (ph)
      PH_ADDR: ph_next = PH_CMD;
      PH_CMD:  ph_next = blk ? PH_CNT : PH_DATA;
      default: ph_next = PH_DATA;
    endcase

  always_comb begin
    rd_val = 8'h00;
    for (int i = 0; i < NUM_REGS; i++)
      if (idx == 7'(BASE_IDX + i)) rd_val = cfg_out[i*8 +: 8];
  end

  assign tx_byte = cnt_pend ? BLK_COUNT : rd_val;
  assign wr_fire = (st == ST_RX) && scl_fall && (bitcnt == 4'd8) &&
                   (ph == PH_DATA) && (wr_left != 8'd0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st       <= ST_IDLE;
      ph       <= PH_ADDR;
      bitcnt   <= '0;
      shreg    <= '0;
      rw       <= 1'b0;
      blk      <= 1'b0;
      idx      <= '0;
      wr_left  <= '0;
      cnt_pend <= 1'b0;
      mst_ack  <= 1'b0;
      sda_oe   <= 1'b0;
    end else if (start_det) begin
      st     <= ST_RX;
      ph     <= PH_ADDR;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      st     <= ST_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (st)
        ST_RX:
          if (scl_rise) begin
            shreg  <= {shreg[6:0], sda_now};
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall && bitcnt == 4'd8) begin
            bitcnt <= '0;
            case (ph)
              PH_ADDR:
                if (shreg[7:1] == DEV_ADDR) begin
                  rw     <= shreg[0];
                  sda_oe <= 1'b1;
                  st     <= ST_RXACK;
                end else begin
                  st <= ST_IDLE;
                end
              PH_CMD: begin
                blk      <= ~shreg[7];
                idx      <= shreg[7] ? shreg[6:0] : IDX_FIRST;
                wr_left  <= shreg[7] ? 8'd1 : 8'd0;
                cnt_pend <= ~shreg[7];
                sda_oe   <= 1'b1;
                st       <= ST_RXACK;
              end
              PH_CNT: begin
                wr_left <= shreg;
                sda_oe  <= 1'b1;
                st      <= ST_RXACK;
              end
              default: begin
                if (wr_left != 8'd0) begin
                  wr_left <= wr_left - 8'd1;
                  idx     <= idx + 7'd1;
                end
                sda_oe <= 1'b1;
                st     <= ST_RXACK;
              end
            endcase
          end
        ST_RXACK:
          if (scl_fall) begin
            if (ph == PH_ADDR && rw) begin
              shreg  <= tx_byte;
              sda_oe <= ~tx_byte[7];
              bitcnt <= '0;
              if (cnt_pend) cnt_pend <= 1'b0;
              else          idx      <= idx + 7'd1;
              st     <= ST_TX;
            end else begin
              sda_oe <= 1'b0;
              ph     <= ph_next;
              st     <= ST_RX;
            end
          end
        ST_TX:
          if (scl_fall) begin
            if (bitcnt == 4'd7) begin
              sda_oe <= 1'b0;
              st     <= ST_TXACK;
            end else begin
              bitcnt <= bitcnt + 4'd1;
              shreg  <= {shreg[6:0], 1'b0};
              sda_oe <= ~shreg[6];
            end
          end
        ST_TXACK:
          if (scl_rise) begin
            mst_ack <= ~sda_now;
          end else if (scl_fall) begin
            if (mst_ack) begin
              shreg  <= tx_byte;
              sda_oe <= ~tx_byte[7];
              bitcnt <= '0;
              if (cnt_pend) cnt_pend <= 1'b0;
              else          idx      <= idx + 7'd1;
              st     <= ST_TX;
            end else begin
              st <= ST_IDLE;
            end
          end
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      ctl0_q <= 8'h00;
    else if (wr_fire && idx == IDX_FIRST)
      ctl0_q <= ctl0_q[3] ? shreg : {ctl0_q[7:4], shreg[3], ctl0_q[2], shreg[1:0]};

  assign cfg_out[7:0]  = ctl0_q[3] ? ctl0_q
                                   : {strap_fs[3:0], ctl0_q[3], strap_fs[4], ctl0_q[1:0]};
  assign cfg_out[15:8] = {2'b00, strap_mult, strap_fs};

  for (genvar g = 2; g < NUM_REGS; g++) begin : g_reg
    logic [7:0] r_q;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)
        r_q <= 8'h00;
      else if (wr_fire && idx == 7'(BASE_IDX + g))
        r_q <= shreg;
    assign cfg_out[g*8 +: 8] = r_q;
  end

endmodule

// File: rtl/smbus_clkcfg_chk.sv
module smbus_clkcfg_chk #(
  parameter int NUM_REGS = 11
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  scl_i,
  input logic                  sda_oe,
  input logic                  idle_w,
  input logic                  scl_fall,
  input logic [4:0]            strap_fs,
  input logic                  strap_mult,
  input logic [7:0]            ctl0_q,
  input logic [NUM_REGS*8-1:0] cfg_out
);

  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);  // R9

  AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    idle_w |-> !sda_oe);  // R1

  AST_CFG_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(strap_fs) && $stable(strap_mult) && !$stable(cfg_out)) |-> $past(scl_fall));  // R2

  AST_FS_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ctl0_q[3]) |-> $stable({ctl0_q[7:4], ctl0_q[2]}));  // R6

endmodule

bind smbus_clkcfg_slave smbus_clkcfg_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe), .idle_w(idle_w),
  .scl_fall(scl_fall), .strap_fs(strap_fs), .strap_mult(strap_mult),
  .ctl0_q(ctl0_q), .cfg_out(cfg_out)
);

// File: tb/tb_smbus_clkcfg_slave.sv
module tb_smbus_clkcfg_slave;
  localparam int NREG = 11;
  localparam int Q = 10;
  localparam logic [4:0] FS = 5'b10110;
  localparam logic MULT = 1'b1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe, sda_line;
  logic [NREG*8-1:0] cfg_out;
  int n_chk = 0, n_bad = 0, oe_bad = 0;
  logic [7:0] m4 = 8'h00;
  logic [7:0] plain [0:127];

  always #4 clk = ~clk;
  assign sda_line = m_sda & ~sda_oe;

  smbus_clkcfg_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap_fs(FS), .strap_mult(MULT), .cfg_out(cfg_out)
  );

  function automatic logic [7:0] m_read(input int i);
    if (i < 4 || i >= 4 + NREG) return 8'h00;
    if (i == 4) return m4[3] ? m4 : {FS[3:0], m4[3], FS[4], m4[1:0]};
    if (i == 5) return {2'b00, MULT, FS};
    return plain[i];
  endfunction

  task automatic m_write(input int i, input logic [7:0] d);
    if (i == 4) m4 = m4[3] ? d : {m4[7:4], d[3], m4[2], d[1:0]};
    else if (i >= 6 && i < 4 + NREG) plain[i] = d;
  endtask

  task automatic chk_eq(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic chk_cfg(input string tag);
    for (int i = 0; i < NREG; i++) chk_eq(tag, int'(cfg_out[i*8 +: 8]), int'(m_read(4 + i)));
  endtask

  task automatic hp;
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start;
    m_sda = 1'b1; hp; m_scl = 1'b1; hp; m_sda = 1'b0; hp; m_scl = 1'b0; hp;
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; hp; m_scl = 1'b1; hp; m_sda = 1'b1; hp;
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      hp; m_sda = b[i]; hp; m_scl = 1'b1;
      if (sda_oe) oe_bad++;
      hp;
      if (sda_oe) oe_bad++;
      m_scl = 1'b0;
    end
    hp; m_sda = 1'b1; hp; m_scl = 1'b1; hp;
    ack = !sda_line;
    m_scl = 1'b0;
  endtask

  task automatic recv_byte(input bit nack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hp; hp; m_scl = 1'b1; hp; b[i] = sda_line; m_scl = 1'b0;
    end
    hp; m_sda = nack; hp; m_scl = 1'b1;
    if (sda_oe) oe_bad++;
    hp; m_scl = 1'b0; hp; m_sda = 1'b1;
  endtask

  task automatic wr_byte(input logic [6:0] i, input logic [7:0] d, output bit ok);
    bit a0, a1, a2;
    bus_start; send_byte(8'hD2, a0); send_byte({1'b1, i}, a1); send_byte(d, a2); bus_stop;
    ok = a0 & a1 & a2;
    m_write(int'(i), d);
  endtask

  task automatic rd_byte(input logic [6:0] i, output logic [7:0] d, output bit ok);
    bit a0, a1, a2;
    bus_start; send_byte(8'hD2, a0); send_byte({1'b1, i}, a1);
    bus_start; send_byte(8'hD3, a2); recv_byte(1'b1, d); bus_stop;
    ok = a0 & a1 & a2;
  endtask

  task automatic t_reset;
    chk_eq("R10 sda_oe after reset", int'(sda_oe), 0);
    chk_cfg("R10 reset register bank");
  endtask

  task automatic t_addr_mismatch;
    bit a;
    bus_start; send_byte(8'hA4, a);
    chk_eq("R1 foreign address acked", int'(a), 0);
    send_byte(8'hD2, a);
    chk_eq("R1 byte after foreign address acked", int'(a), 0);
    bus_stop;
    bus_start; send_byte(8'hD2, a); bus_stop;
    chk_eq("R1 own address ack", int'(a), 1);
  endtask

  task automatic t_byte_rw;
    bit ok; logic [7:0] d;
    wr_byte(7'd7, 8'h5A, ok);
    chk_eq("R2 byte write acks", int'(ok), 1);
    chk_eq("R2 byte write lands at index 7", int'(cfg_out[3*8 +: 8]), 8'h5A);
    wr_byte(7'd14, 8'hC3, ok);
    rd_byte(7'd7, d, ok);
    chk_eq("R3 byte read index 7", int'(d), 8'h5A);
    chk_eq("R3 byte read acks", int'(ok), 1);
    rd_byte(7'd14, d, ok);
    chk_eq("R3 byte read last index", int'(d), 8'hC3);
    chk_cfg("R2 bank after byte writes");
  endtask

  task automatic t_fs_gating;
    bit ok; logic [7:0] d;
    wr_byte(7'd4, 8'hF5, ok);
    rd_byte(7'd4, d, ok);
    chk_eq("R6 hardware mode hides written FS bits", int'(d), 8'h65);
    wr_byte(7'd4, 8'h08, ok);
    chk_eq("R6 mode switch keeps stored FS", int'(cfg_out[7:0]), int'(m_read(4)));
    wr_byte(7'd4, 8'hAC, ok);
    rd_byte(7'd4, d, ok);
    chk_eq("R6 software mode FS writable", int'(d), 8'hAC);
    wr_byte(7'd4, 8'h00, ok);
    rd_byte(7'd4, d, ok);
    chk_eq("R6 back to hardware straps", int'(d), int'(m_read(4)));
    chk_eq("R6 hardware view value", int'(d), 8'h64);
  endtask

  task automatic t_reg5;
    bit ok; logic [7:0] d;
    wr_byte(7'd5, 8'hFF, ok);
    rd_byte(7'd5, d, ok);
    chk_eq("R7 strap register read-only", int'(d), 8'h36);
    chk_cfg("R7 bank after strap register write");
  endtask

  task automatic t_unimpl;
    bit ok; logic [7:0] d;
    wr_byte(7'd2, 8'h77, ok);
    chk_eq("R8 low index write still acked", int'(ok), 1);
    rd_byte(7'd2, d, ok);
    chk_eq("R8 low index reads zero", int'(d), 0);
    wr_byte(7'd20, 8'h55, ok);
    rd_byte(7'd20, d, ok);
    chk_eq("R8 high index reads zero", int'(d), 0);
    chk_cfg("R8 bank untouched");
  endtask

  task automatic t_block_write;
    bit a; int nack = 0;
    logic [7:0] data [5] = '{8'h08, 8'hFF, 8'h33, 8'h44, 8'h99};
    bus_start;
    send_byte(8'hD2, a); if (!a) nack++;
    send_byte(8'h00, a); if (!a) nack++;
    send_byte(8'd4, a);  if (!a) nack++;
    for (int i = 0; i < 5; i++) begin
      send_byte(data[i], a); if (!a) nack++;
      if (i < 4) m_write(4 + i, data[i]);
    end
    bus_stop;
    chk_eq("R4 block write all acked", nack, 0);
    chk_eq("R4 byte beyond count discarded", int'(cfg_out[4*8 +: 8]), 0);
    chk_cfg("R4 bank after block write");
    bus_start;
    send_byte(8'hD2, a); send_byte(8'h00, a); send_byte(8'd5, a);
    send_byte(8'h0B, a); m_write(4, 8'h0B);
    send_byte(8'h00, a);
    bus_stop;
    chk_eq("R4 early stop keeps first byte", int'(cfg_out[7:0]), 8'h0B);
    chk_eq("R4 early stop leaves index 6", int'(cfg_out[2*8 +: 8]), 8'h33);
  endtask

  task automatic t_block_read;
    bit a; logic [7:0] d;
    bus_start; send_byte(8'hD2, a); send_byte(8'h00, a);
    bus_start; send_byte(8'hD3, a);
    chk_eq("R5 read address acked", int'(a), 1);
    recv_byte(1'b0, d);
    chk_eq("R5 block count", int'(d), NREG);
    for (int i = 4; i < 4 + NREG; i++) begin
      recv_byte(1'b0, d);
      chk_eq($sformatf("R5 block read index %0d", i), int'(d), int'(m_read(i)));
    end
    recv_byte(1'b1, d);
    chk_eq("R8 block read past last register", int'(d), 0);
    bus_stop;
    chk_eq("R5 bus released after NACK", int'(sda_oe), 0);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) plain[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset;
    t_addr_mismatch;
    t_byte_rw;
    t_fs_gating;
    t_reg5;
    t_unimpl;
    t_block_write;
    t_block_read;
    chk_eq("R9 drive during master bits", oe_bad, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got 0x0 expected 0x1 (run did not complete)");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule